// File: doc/BRIEF.md
# Coprocessor Fault and Maintenance Register Unit

This unit sits on a coprocessor register access port. Each cycle the port may present one access: a valid strobe, a read or write flag, a register number, two sub-field selectors (CRm and opcode_2) and write data. The unit answers with read data and an undefined-access flag in the same cycle. It claims three register numbers. Register 6 holds the fault address. Register 7 carries cache maintenance. Register 8 carries TLB maintenance. Every other register number belongs to other units and is ignored here.

The fault address register is loaded with the address of a data access that aborted. Before it is stored, that address is relocated by the current process ID: when the top seven address bits are all zero, the process ID is placed in those bits. Instruction-fetch faults leave the register alone. Software can also write the register, for example to restore it after a debugger has used it.

A valid maintenance write produces a single-cycle command pulse one clock later. The commands are invalidate the whole cache, invalidate the whole TLB, and invalidate one TLB entry. A single-entry pulse comes with the target address. A sub-field combination that is not defined raises the undefined-access flag and produces no pulse.

Top module: `cp_fault_maint`

## Requirements
- R1: A valid read of register 6 with CRm = 0 and opcode_2 = 0 returns the fault address register on `acc_rdata` in the same cycle, with `acc_undef` low.
- R2: A fault with `flt_is_data` low (an instruction-fetch fault) leaves the fault address register unchanged.
- R3: A valid write to register 6 with CRm = 0 and opcode_2 = 0 loads `acc_wdata` into the fault address register at the next clock edge.
- R4: A data fault loads the relocated address at the next clock edge. The relocated address equals `flt_vaddr` when bits [31:25] are nonzero. Otherwise bits [31:25] are replaced by `pid` and bits [24:0] are kept.
- R5: A valid write to register 7 with opcode_2 = 0 and CRm = 7 drives `cache_inv_all` high for exactly the following cycle.
- R6: When a data fault and a register 6 write occur in the same cycle, the fault wins. The register resets to zero.
- R7: A valid write to register 8 with opcode_2 = 0 and CRm in {5, 6, 7} drives `tlb_inv_all` high for exactly the following cycle.
- R8: A valid write to register 8 with opcode_2 = 1 and CRm in {5, 6, 7} drives `tlb_inv_one` high for exactly the following cycle, with `tlb_inv_addr` equal to the written data during that cycle.
- R9: A valid read of register 7 or register 8 raises `acc_undef` in the same cycle and returns zero read data.
- R10: A register 7 or register 8 write with any other sub-field combination, or a register 6 access with nonzero CRm or opcode_2, raises `acc_undef`. It produces no pulse and does not change the fault address register.
- R11: An access to any register number other than 6, 7 or 8 leaves `acc_undef` low, returns zero read data and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_reg | input | 4 | Coprocessor register number |
| acc_crm | input | 4 | CRm sub-field |
| acc_op2 | input | 3 | opcode_2 sub-field |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data (same cycle) |
| acc_undef | output | 1 | Undefined access (same cycle) |
| flt_valid | input | 1 | An abort is reported this cycle |
| flt_is_data | input | 1 | 1 = data abort, 0 = instruction-fetch abort |
| flt_vaddr | input | 32 | Virtual address of the aborted access |
| pid | input | 7 | Current process ID used for relocation |
| cache_inv_all | output | 1 | Invalidate-whole-cache pulse |
| tlb_inv_all | output | 1 | Invalidate-whole-TLB pulse |
| tlb_inv_one | output | 1 | Invalidate-single-TLB-entry pulse |
| tlb_inv_addr | output | 32 | Target address that goes with `tlb_inv_one` |

## Verification
The bench aims at the relocation edge: addresses whose top seven bits are all zero against ones where only bit 25 is set. A design that tested the wrong bit range would store a raw or a corrupted address. It hits a data fault and a register 6 write in the same cycle, where the wrong priority would keep the software value. It also sends instruction-fetch faults, which a careless design would capture. Near-miss sub-field codes (CRm 4 or 8, opcode_2 2, nonzero fields on register 6) are mixed with the valid ones, so a loose decoder would either fire a pulse or fail to flag the access as undefined. Back-to-back maintenance writes check that each pulse lasts exactly one cycle and that the single-entry address follows its own command.

// File: rtl/cp_fm_pkg.sv
package cp_fm_pkg;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_PID_W  = 7;
  localparam int unsigned DEF_REG_W  = 4;
  localparam int unsigned DEF_CRM_W  = 4;
  localparam int unsigned DEF_OP2_W  = 3;

  localparam int unsigned REGNUM_FAULT = 6;
  localparam int unsigned REGNUM_CACHE = 7;
  localparam int unsigned REGNUM_TLB   = 8;

  typedef enum logic [1:0] {
    CMD_NONE     = 2'd0,
    CMD_CACHE    = 2'd1,
    CMD_TLB_ALL  = 2'd2,
    CMD_TLB_ONE  = 2'd3
  } maint_cmd_e;
endpackage

// File: rtl/cp_fm_decode.sv
module cp_fm_decode
  import cp_fm_pkg::*;
#(
  parameter int unsigned REG_W = DEF_REG_W,
  parameter int unsigned CRM_W = DEF_CRM_W,
  parameter int unsigned OP2_W = DEF_OP2_W
) (
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [REG_W-1:0] acc_reg,
  input  logic [CRM_W-1:0] acc_crm,
  input  logic [OP2_W-1:0] acc_op2,
  output maint_cmd_e       cmd,
  output logic             far_we,
  output logic             far_rd,
  output logic             undef
);
  logic hit_fault, hit_cache, hit_tlb;
  logic fields_zero, crm_tlb_ok, cache_ok, tlb_all_ok, tlb_one_ok;

  assign hit_fault   = acc_valid && (acc_reg == REG_W'(REGNUM_FAULT));
  assign hit_cache   = acc_valid && (acc_reg == REG_W'(REGNUM_CACHE));
  assign hit_tlb     = acc_valid && (acc_reg == REG_W'(REGNUM_TLB));
  assign fields_zero = (acc_crm == '0) && (acc_op2 == '0);

  // TLB maintenance accepts CRm 5, 6 or 7
  assign crm_tlb_ok  = (acc_crm == CRM_W'(5)) || (acc_crm == CRM_W'(6)) ||
                       (acc_crm == CRM_W'(7));
  assign cache_ok    = acc_write && (acc_op2 == '0) && (acc_crm == CRM_W'(7));
  assign tlb_all_ok  = acc_write && (acc_op2 == '0) && crm_tlb_ok;
  assign tlb_one_ok  = acc_write && (acc_op2 == OP2_W'(1)) && crm_tlb_ok;

  always_comb begin
    cmd = CMD_NONE;
    if (hit_cache && cache_ok)        cmd = CMD_CACHE;
    else if (hit_tlb && tlb_all_ok)   cmd = CMD_TLB_ALL;
    else if (hit_tlb && tlb_one_ok)   cmd = CMD_TLB_ONE;
  end

  assign far_we = hit_fault && fields_zero && acc_write;
  assign far_rd = hit_fault && fields_zero && !acc_write;
  assign undef  = (hit_fault && !fields_zero) ||
                  (hit_cache && !cache_ok) ||
                  (hit_tlb && !(tlb_all_ok || tlb_one_ok));
endmodule

// File: rtl/cp_fm_far.sv
module cp_fm_far #(
  parameter int unsigned ADDR_W = cp_fm_pkg::DEF_ADDR_W,
  parameter int unsigned PID_W  = cp_fm_pkg::DEF_PID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_data,
  input  logic [ADDR_W-1:0] flt_addr,
  input  logic [PID_W-1:0]  pid,
  input  logic              sw_we,
  input  logic [ADDR_W-1:0] sw_data,
  output logic [ADDR_W-1:0] far_q
);
  localparam int unsigned LOW_W = ADDR_W - PID_W;

  // Process-ID relocation of a virtual address
  function automatic logic [ADDR_W-1:0] relocate(input logic [ADDR_W-1:0] va,
                                                 input logic [PID_W-1:0]  p);
    if (va[ADDR_W-1:LOW_W] == '0) return {p, va[LOW_W-1:0]};
    return va;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)        far_q <= '0;
    else if (flt_data) far_q <= relocate(flt_addr, pid);
    else if (sw_we)    far_q <= sw_data;
  end

  assert_fault_loads_relocated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flt_data |=> far_q == relocate($past(flt_addr), $past(pid)));

  assert_sw_write_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !flt_data) |=> far_q == $past(sw_data));

  assert_fault_beats_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_data && sw_we && (sw_data != relocate(flt_addr, pid))) |=> far_q != $past(sw_data));

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flt_data && !sw_we) |=> $stable(far_q));
endmodule

// File: rtl/cp_fm_pulse.sv
module cp_fm_pulse
  import cp_fm_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  maint_cmd_e        cmd,
  input  logic [ADDR_W-1:0] addr,
  output logic              cache_inv_all,
  output logic              tlb_inv_all,
  output logic              tlb_inv_one,
  output logic [ADDR_W-1:0] tlb_inv_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cache_inv_all <= 1'b0;
      tlb_inv_all   <= 1'b0;
      tlb_inv_one   <= 1'b0;
      tlb_inv_addr  <= '0;
    end else begin
      cache_inv_all <= (cmd == CMD_CACHE);
      tlb_inv_all   <= (cmd == CMD_TLB_ALL);
      tlb_inv_one   <= (cmd == CMD_TLB_ONE);
      if (cmd == CMD_TLB_ONE) tlb_inv_addr <= addr;
    end
  end

  assert_single_command_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cache_inv_all, tlb_inv_all, tlb_inv_one}));

  assert_entry_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_TLB_ONE) |=> (tlb_inv_one && tlb_inv_addr == $past(addr)));

  assert_no_cmd_no_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_NONE) |=> !(cache_inv_all || tlb_inv_all || tlb_inv_one));
endmodule

// File: rtl/cp_fault_maint.sv
module cp_fault_maint
  import cp_fm_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned PID_W  = DEF_PID_W,
  parameter int unsigned REG_W  = DEF_REG_W,
  parameter int unsigned CRM_W  = DEF_CRM_W,
  parameter int unsigned OP2_W  = DEF_OP2_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [REG_W-1:0]  acc_reg,
  input  logic [CRM_W-1:0]  acc_crm,
  input  logic [OP2_W-1:0]  acc_op2,
  input  logic [ADDR_W-1:0] acc_wdata,
  output logic [ADDR_W-1:0] acc_rdata,
  output logic              acc_undef,
  input  logic              flt_valid,
  input  logic              flt_is_data,
  input  logic [ADDR_W-1:0] flt_vaddr,
  input  logic [PID_W-1:0]  pid,
  output logic              cache_inv_all,
  output logic              tlb_inv_all,
  output logic              tlb_inv_one,
  output logic [ADDR_W-1:0] tlb_inv_addr
);
  maint_cmd_e        dec_cmd;
  logic              far_we, far_rd, flt_data;
  logic [ADDR_W-1:0] far_q;

  assign flt_data = flt_valid && flt_is_data;

  cp_fm_decode #(.REG_W(REG_W), .CRM_W(CRM_W), .OP2_W(OP2_W)) u_decode (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_reg   (acc_reg),
    .acc_crm   (acc_crm),
    .acc_op2   (acc_op2),
    .cmd       (dec_cmd),
    .far_we    (far_we),
    .far_rd    (far_rd),
    .undef     (acc_undef)
  );

  cp_fm_far #(.ADDR_W(ADDR_W), .PID_W(PID_W)) u_far (
    .clk      (clk),
    .rst_n    (rst_n),
    .flt_data (flt_data),
    .flt_addr (flt_vaddr),
    .pid      (pid),
    .sw_we    (far_we),
    .sw_data  (acc_wdata),
    .far_q    (far_q)
  );

  cp_fm_pulse #(.ADDR_W(ADDR_W)) u_pulse (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd           (dec_cmd),
    .addr          (acc_wdata),
    .cache_inv_all (cache_inv_all),
    .tlb_inv_all   (tlb_inv_all),
    .tlb_inv_one   (tlb_inv_one),
    .tlb_inv_addr  (tlb_inv_addr)
  );

  assign acc_rdata = far_rd ? far_q : '0;

  assert_fetch_fault_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !flt_is_data && !far_we) |=> $stable(far_q));

  assert_read_maint_undef_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write &&
     (acc_reg == REG_W'(REGNUM_CACHE) || acc_reg == REG_W'(REGNUM_TLB)))
      |-> (acc_undef && acc_rdata == '0));

  assert_undef_no_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_undef |=> !(cache_inv_all || tlb_inv_all || tlb_inv_one));

  assert_foreign_reg_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_reg != REG_W'(REGNUM_FAULT) && acc_reg != REG_W'(REGNUM_CACHE) &&
     acc_reg != REG_W'(REGNUM_TLB)) |-> (!acc_undef && acc_rdata == '0));
endmodule

// File: tb/tb_cp_fault_maint.sv
`timescale 1ns/1ps
module tb_cp_fault_maint;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [3:0]  acc_reg = '0, acc_crm = '0;
  logic [2:0]  acc_op2 = '0;
  logic [31:0] acc_wdata = '0, acc_rdata;
  logic        acc_undef;
  logic        flt_valid = 1'b0, flt_is_data = 1'b0;
  logic [31:0] flt_vaddr = '0;
  logic [6:0]  pid = '0;
  logic        cache_inv_all, tlb_inv_all, tlb_inv_one;
  logic [31:0] tlb_inv_addr;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_far = '0, exp_addr = '0;
  logic exp_c = 0, exp_ta = 0, exp_to = 0;

  always #2.5 clk = ~clk;

  cp_fault_maint dut (.*);

  // bench view of relocation: shift-based, not slice-based
  function automatic logic [31:0] moved(input logic [31:0] a, input logic [6:0] p);
    if ((a >> 25) == 32'd0) return a | ({25'd0, p} << 25);
    return a;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic w, input logic [3:0] r, input logic [3:0] c,
                      input logic [2:0] o, input logic [31:0] wd, input logic fv,
                      input logic fd, input logic [31:0] fa, input logic [6:0] p);
    logic ok6, okc, okta, okto, eu;
    string tag;
    @(negedge clk);
    chk({31'd0, cache_inv_all}, {31'd0, exp_c}, "R5 cache pulse");
    chk({31'd0, tlb_inv_all}, {31'd0, exp_ta}, "R7 tlb-all pulse");
    chk({31'd0, tlb_inv_one}, {31'd0, exp_to}, "R8 tlb-one pulse");
    if (exp_to) chk(tlb_inv_addr, exp_addr, "R8 tlb-one address");
    acc_valid = v; acc_write = w; acc_reg = r; acc_crm = c; acc_op2 = o; acc_wdata = wd;
    flt_valid = fv; flt_is_data = fd; flt_vaddr = fa; pid = p;
    #1;
    ok6  = (r == 4'd6) && (c == 4'd0) && (o == 3'd0);
    okc  = w && (r == 4'd7) && (o == 3'd0) && (c == 4'd7);
    okta = w && (r == 4'd8) && (o == 3'd0) && (c >= 4'd5) && (c <= 4'd7);
    okto = w && (r == 4'd8) && (o == 3'd1) && (c >= 4'd5) && (c <= 4'd7);
    eu   = v && ((r == 4'd6 && !ok6) || (r == 4'd7 && !okc) || (r == 4'd8 && !(okta || okto)));
    if (v && !w && (r == 4'd7 || r == 4'd8)) tag = "R9 undef flag";
    else if (r == 4'd6 || r == 4'd7 || r == 4'd8) tag = "R10 undef flag";
    else tag = "R11 undef flag";
    chk({31'd0, acc_undef}, {31'd0, eu}, tag);
    chk(acc_rdata, (v && !w && ok6) ? exp_far : 32'd0, "R1 read data");
    exp_c  = v && okc;
    exp_ta = v && okta;
    exp_to = v && okto;
    if (exp_to) exp_addr = wd;
    if (fv && fd)         exp_far = moved(fa, p);
    else if (v && w && ok6) exp_far = wd;
  endtask

  task automatic rd6();
    step(1, 0, 4'd6, 4'd0, 3'd0, 32'd0, 0, 0, 32'd0, 7'd0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R6: reset value zero; outputs idle
    rd6();
    chk(acc_rdata, 32'd0, "R6 reset value");
    // R4 relocation edges
    step(0, 0, 0, 0, 0, 0, 1, 1, 32'h01FF_FFFF, 7'h55); rd6();
    step(0, 0, 0, 0, 0, 0, 1, 1, 32'h0200_0000, 7'h7F); rd6();
    // R2 fetch fault ignored
    step(0, 0, 0, 0, 0, 0, 1, 0, 32'h1234_5678, 7'h01); rd6();
    // R3 write then R6 priority
    step(1, 1, 4'd6, 4'd0, 3'd0, 32'hDEAD_BEEF, 0, 0, 0, 0); rd6();
    step(1, 1, 4'd6, 4'd0, 3'd0, 32'hCAFE_0000, 1, 1, 32'h0000_0042, 7'h03); rd6();
    // R10 nonzero sub-fields on register 6
    step(1, 1, 4'd6, 4'd1, 3'd0, 32'h1111_1111, 0, 0, 0, 0); rd6();
    // back-to-back maintenance R5 R7 R8 and near misses
    step(1, 1, 4'd7, 4'd7, 3'd0, 0, 0, 0, 0, 0);
    step(1, 1, 4'd8, 4'd5, 3'd1, 32'hABCD_0123, 0, 0, 0, 0);
    step(1, 1, 4'd8, 4'd7, 3'd1, 32'h0000_1000, 0, 0, 0, 0);
    step(1, 1, 4'd8, 4'd6, 3'd0, 0, 0, 0, 0, 0);
    step(1, 1, 4'd8, 4'd4, 3'd1, 0, 0, 0, 0, 0);
    step(1, 1, 4'd7, 4'd8, 3'd0, 0, 0, 0, 0, 0);
    step(1, 1, 4'd8, 4'd6, 3'd2, 0, 0, 0, 0, 0);
    step(1, 0, 4'd7, 4'd7, 3'd0, 0, 0, 0, 0, 0);   // R9
    step(1, 0, 4'd8, 4'd5, 3'd0, 0, 0, 0, 0, 0);   // R9
    step(1, 1, 4'd5, 4'd0, 3'd0, 32'h5555_AAAA, 0, 0, 0, 0); rd6(); // R11
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] r, c;
      logic [2:0] o;
      logic [31:0] fa;
      int k;
      k = $urandom_range(0, 9);
      r = (k < 4) ? 4'd6 : (k < 6) ? 4'd7 : (k < 8) ? 4'd8 : 4'($urandom_range(0, 15));
      k = $urandom_range(0, 9);
      c = (k < 2) ? 4'd0 : (k < 8) ? 4'($urandom_range(5, 7)) : 4'($urandom_range(0, 15));
      o = ($urandom_range(0, 9) < 8) ? 3'($urandom_range(0, 1)) : 3'($urandom_range(0, 7));
      fa = $urandom();
      if ($urandom_range(0, 1) == 0) fa[31:25] = 7'd0;
      step($urandom_range(0, 9) < 8, $urandom_range(0, 1) == 1, r, c, o, $urandom(),
           $urandom_range(0, 9) < 3, $urandom_range(0, 1) == 1, fa, 7'($urandom()));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule